// File: doc/BRIEF.md
# NIC interrupt status aggregator

This block holds the interrupt status word of a network controller. Single-cycle events from the DMA engines and the queue logic set sticky status bits. Three bits come from threshold comparisons that the block makes itself: the transmit FIFO fill level, the free-entry count of a receive completion queue, and the number of buffers posted in a receive buffer queue. That last count is derived from the queue's producer and consumer indexes. A read-only summary bit gathers the transmit and early-receive group, and a per-bit mask selects which status bits drive the interrupt line.

Software reaches the block over a simple register port with one select line. Select 0 is the status word and select 1 is the mask. A read of the status word returns its value and clears every sticky bit. A write clears each bit where the written data holds a 1. The early-receive bit also clears by itself when the matching whole-frame completion arrives.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, status, mask and `irq` are 0. A status read (`bus_sel`=0, `bus_rd`=1) returns the current word on `bus_rdata` in that cycle and clears all sticky bits at the following clock edge.
- R2: Status bit 15 is read-only. It reads as the OR of bits 8 to 14, and bits 16 to 19 do not affect it. Writing a 1 to bit 15 has no effect.
- R3: Bit 19 sets when any of target abort, master abort or bad descriptor pulses. A parity error sets it only while `stop_on_parity` is 1.
- R4: Bit 18 sets when `tx_dma_busy` is 1 and `tx_fifo_bytes` < `tx_low_thresh`.
- R5: Bit 16 sets only in a cycle where `rx1_fetch` is 1 and the available count ((`rx1_prod` − `rx1_cons`) mod 2^IDX_W) is below `rx1_low_thresh`. Without a fetch, the bit does not set.
- R6: Bit 17 sets when `rx2_cq_free` < `rx2_cq_thresh`.
- R7: Bits 12, 13 and 14 set on `tx_last_queued_done`, `tx_frame_dma_done` and `tx_frame_sent` respectively. Bit 11 sets on `rx2_early`.
- R8: `rx2_frame_done` clears bit 11 at the next edge. This holds even if `rx2_early` pulses in the same cycle.
- R9: A status write (`bus_sel`=0, `bus_wr`=1) clears exactly the bits whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R10: Each threshold condition (R4, R5, R6) sets its bit only on the change from not-low to low. A condition that stays low does not set the bit again after it has been cleared. For R5 the change is judged across fetch attempts.
- R11: If an event and a read-clear or a write-1 clear reach the same bit in the same cycle, the bit is set afterwards.
- R12: The mask is written and read at `bus_sel`=1, and reading it clears nothing. `irq` is the OR of the status word (including bit 15) ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 status, 1 mask |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Read data for the selected register |
| dma_tgt_abort | input | 1 | DMA target abort pulse |
| dma_mst_abort | input | 1 | DMA master abort pulse |
| dma_bad_desc | input | 1 | Bad descriptor pulse |
| dma_parity_err | input | 1 | Data parity error pulse |
| stop_on_parity | input | 1 | Enables parity errors as a DMA error cause |
| tx_last_queued_done | input | 1 | Completion write-back for the last queued transmit frame |
| tx_frame_dma_done | input | 1 | Completion write-back for a frame fetched from the host |
| tx_frame_sent | input | 1 | Completion write-back for a frame sent on the wire |
| rx2_early | input | 1 | Early-receive byte count reached on queue 2 |
| rx2_frame_done | input | 1 | Whole frame transferred on queue 2 |
| tx_dma_busy | input | 1 | A transmit frame is being moved by DMA |
| tx_fifo_bytes | input | LVL_W | Transmit FIFO fill level |
| tx_low_thresh | input | LVL_W | Transmit FIFO low threshold |
| rx2_cq_free | input | CNT_W | Free entries in receive completion queue 2 |
| rx2_cq_thresh | input | CNT_W | Completion queue low threshold |
| rx1_fetch | input | 1 | Buffer descriptor fetch attempt on queue 1 |
| rx1_prod | input | IDX_W | Queue 1 producer index |
| rx1_cons | input | IDX_W | Queue 1 consumer index |
| rx1_low_thresh | input | IDX_W | Queue 1 low-buffer threshold |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every producer, consumer and threshold combination of an 8-entry buffer queue. A subtractor without wrap, or a comparison made outside fetch cycles, would then mark the wrong combinations as low. It walks all 32 combinations of the DMA error causes and the parity enable, which catches a parity cause that ignores its gate. It holds the threshold conditions low across a clear, so a level-triggered design would set the bit again and be caught. It also places events in the same cycle as read-clears, write-1 clears and frame-done, which shows a design that drops an event or lets the early bit survive completion.

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
  parameter int IDX_W = 4,
  parameter int LVL_W = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [19:0]      bus_wdata,
  output logic [19:0]      bus_rdata,
  input  logic             dma_tgt_abort,
  input  logic             dma_mst_abort,
  input  logic             dma_bad_desc,
  input  logic             dma_parity_err,
  input  logic             stop_on_parity,
  input  logic             tx_last_queued_done,
  input  logic             tx_frame_dma_done,
  input  logic             tx_frame_sent,
  input  logic             rx2_early,
  input  logic             rx2_frame_done,
  input  logic             tx_dma_busy,
  input  logic [LVL_W-1:0] tx_fifo_bytes,
  input  logic [LVL_W-1:0] tx_low_thresh,
  input  logic [CNT_W-1:0] rx2_cq_free,
  input  logic [CNT_W-1:0] rx2_cq_thresh,
  input  logic             rx1_fetch,
  input  logic [IDX_W-1:0] rx1_prod,
  input  logic [IDX_W-1:0] rx1_cons,
  input  logic [IDX_W-1:0] rx1_low_thresh,
  output logic             irq
);

  localparam logic [19:0] STICKY = 20'hF7800;
  localparam int B_EARLY = 11, B_QDONE = 12, B_DDONE = 13, B_SENT = 14;
  localparam int B_SUM = 15, B_BUFLO = 16, B_CQLO = 17, B_TXLO = 18, B_DMAERR = 19;

  logic [19:0] stat_q, mask_q, set_v, clr_bus, view;
  logic [IDX_W-1:0] avail;
  logic tx_low, cq_low, buf_low;
  logic tx_low_q, cq_low_q, buf_low_q;

  assign avail   = rx1_prod - rx1_cons;
  assign tx_low  = tx_dma_busy && (tx_fifo_bytes < tx_low_thresh);
  assign cq_low  = rx2_cq_free < rx2_cq_thresh;
  assign buf_low = avail < rx1_low_thresh;

  always_comb begin
    set_v           = '0;
    set_v[B_DMAERR] = dma_tgt_abort | dma_mst_abort | dma_bad_desc |
                      (dma_parity_err & stop_on_parity);
    set_v[B_TXLO]   = tx_low & ~tx_low_q;
    set_v[B_CQLO]   = cq_low & ~cq_low_q;
    set_v[B_BUFLO]  = rx1_fetch & buf_low & ~buf_low_q;
    set_v[B_SENT]   = tx_frame_sent;
    set_v[B_DDONE]  = tx_frame_dma_done;
    set_v[B_QDONE]  = tx_last_queued_done;
    set_v[B_EARLY]  = rx2_early;
  end

  assign clr_bus = ((bus_rd && !bus_sel) ? STICKY : 20'h0) |
                   ((bus_wr && !bus_sel) ? bus_wdata : 20'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      mask_q    <= '0;
      tx_low_q  <= 1'b0;
      cq_low_q  <= 1'b0;
      buf_low_q <= 1'b0;
    end else begin
      stat_q <= (((stat_q & ~clr_bus) | set_v) & STICKY) &
                ~(rx2_frame_done ? (20'h1 << B_EARLY) : 20'h0);
      if (bus_wr && bus_sel) mask_q <= bus_wdata;
      tx_low_q <= tx_low;
      cq_low_q <= cq_low;
      if (rx1_fetch) buf_low_q <= buf_low;
    end
  end

  always_comb begin
    view        = stat_q;
    view[B_SUM] = |stat_q[14:8];
  end

  assign bus_rdata = bus_sel ? mask_q : view;
  assign irq       = |(view & mask_q);

  // R1
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_sel && set_v == 20'h0) |=> (stat_q == 20'h0));

  // R3
  parity_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_parity_err && !stop_on_parity && !dma_tgt_abort && !dma_mst_abort &&
     !dma_bad_desc && !stat_q[B_DMAERR]) |=> !stat_q[B_DMAERR]);

  // R8
  early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx2_frame_done |=> !stat_q[B_EARLY]);

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && bus_wdata[B_DDONE] && !tx_frame_dma_done) |=> !stat_q[B_DDONE]);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_sent |=> stat_q[B_SENT]);

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 20'h0) |-> !irq);

endmodule

// File: tb/nic_irq_status_tb_top.sv
module nic_irq_status_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [19:0] bus_wdata = 0, bus_rdata;
  logic dma_tgt_abort = 0, dma_mst_abort = 0, dma_bad_desc = 0, dma_parity_err = 0, stop_on_parity = 0;
  logic tx_last_queued_done = 0, tx_frame_dma_done = 0, tx_frame_sent = 0;
  logic rx2_early = 0, rx2_frame_done = 0, tx_dma_busy = 0;
  logic [3:0] tx_fifo_bytes = 4'd15, tx_low_thresh = 4'd8;
  logic [2:0] rx2_cq_free = 3'd7, rx2_cq_thresh = 3'd4;
  logic rx1_fetch = 0;
  logic [2:0] rx1_prod = 0, rx1_cons = 0, rx1_low_thresh = 0;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [19:0] v;

  always #10 clk = ~clk;

  nic_irq_status #(.IDX_W(3), .LVL_W(4), .CNT_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_tgt_abort(dma_tgt_abort), .dma_mst_abort(dma_mst_abort), .dma_bad_desc(dma_bad_desc),
    .dma_parity_err(dma_parity_err), .stop_on_parity(stop_on_parity),
    .tx_last_queued_done(tx_last_queued_done), .tx_frame_dma_done(tx_frame_dma_done),
    .tx_frame_sent(tx_frame_sent), .rx2_early(rx2_early), .rx2_frame_done(rx2_frame_done),
    .tx_dma_busy(tx_dma_busy), .tx_fifo_bytes(tx_fifo_bytes), .tx_low_thresh(tx_low_thresh),
    .rx2_cq_free(rx2_cq_free), .rx2_cq_thresh(rx2_cq_thresh), .rx1_fetch(rx1_fetch),
    .rx1_prod(rx1_prod), .rx1_cons(rx1_cons), .rx1_low_thresh(rx1_low_thresh), .irq(irq));

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [19:0] d);
    bus_sel = sel; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic sel, input logic [19:0] d);
    bus_sel = sel; bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    #1 check("R1 irq reset", {19'h0, irq}, 20'h0);
    rd(1, v); check("R1 mask reset", v, 20'h0);
    rd(0, v); check("R1 status reset", v, 20'h0);

    // R3 all cause combinations
    for (int i = 0; i < 32; i++) begin
      dma_tgt_abort = i[0]; dma_mst_abort = i[1]; dma_bad_desc = i[2];
      dma_parity_err = i[3]; stop_on_parity = i[4];
      tick();
      {dma_tgt_abort, dma_mst_abort, dma_bad_desc, dma_parity_err} = 0;
      rd(0, v);
      check("R3 dma error", v,
            (i[0] | i[1] | i[2] | (i[3] & i[4])) ? 20'h80000 : 20'h0);
    end
    stop_on_parity = 0;

    // R4 transmit low sweep
    for (int a = 0; a < 2; a++)
      for (int l = 0; l < 16; l++) begin
        tx_dma_busy = 1; tx_fifo_bytes = 15; tick();
        tx_dma_busy = a[0]; tx_fifo_bytes = l[3:0]; tick();
        tx_dma_busy = 0; tx_fifo_bytes = 15;
        rd(0, v);
        check("R4 tx low", v, (a == 1 && l < 8) ? 20'h40000 : 20'h0);
      end
    // R10 sustained low does not re-set bit 18
    tx_dma_busy = 1; tx_fifo_bytes = 2; tick();
    rd(0, v); check("R10 tx low first", v, 20'h40000);
    repeat (3) tick();
    rd(0, v); check("R10 tx low held", v, 20'h0);
    tx_dma_busy = 0; tx_fifo_bytes = 15; tick();

    // R6 completion queue sweep
    for (int f = 0; f < 8; f++) begin
      rx2_cq_free = 7; tick();
      rx2_cq_free = f[2:0]; tick();
      rx2_cq_free = 7;
      rd(0, v);
      check("R6 cq low", v, (f < 4) ? 20'h20000 : 20'h0);
    end
    // R10 sustained completion queue low
    rx2_cq_free = 1; tick();
    rd(0, v); check("R10 cq low first", v, 20'h20000);
    repeat (3) tick();
    rd(0, v); check("R10 cq low held", v, 20'h0);
    rx2_cq_free = 7; tick();

    // R5 exhaustive buffer-low sweep
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 8; c++)
        for (int t = 0; t < 8; t++) begin
          rx1_low_thresh = 0; rx1_fetch = 1; tick();
          rx1_prod = p[2:0]; rx1_cons = c[2:0]; rx1_low_thresh = t[2:0]; tick();
          rx1_fetch = 0;
          rd(0, v);
          check("R5 buffer low", v, (((p - c) & 7) < t) ? 20'h10000 : 20'h0);
        end
    // R5 no fetch, no evaluation
    rx1_low_thresh = 0; rx1_fetch = 1; tick(); rx1_fetch = 0;
    rx1_prod = 0; rx1_cons = 0; rx1_low_thresh = 5;
    repeat (3) tick();
    rd(0, v); check("R5 no fetch", v, 20'h0);
    // R10 repeated low fetches set once
    rx1_fetch = 1; tick(); rx1_fetch = 0;
    rd(0, v); check("R10 buf low first", v, 20'h10000);
    rx1_fetch = 1; tick(); rx1_fetch = 0;
    rd(0, v); check("R10 buf low repeat", v, 20'h0);
    rx1_low_thresh = 0;

    // R7 and R2 single events and summary
    tx_last_queued_done = 1; tick(); tx_last_queued_done = 0;
    rd(0, v); check("R7 bit12", v, 20'h09000);
    tx_frame_dma_done = 1; tick(); tx_frame_dma_done = 0;
    rd(0, v); check("R7 bit13", v, 20'h0A000);
    tx_frame_sent = 1; tick(); tx_frame_sent = 0;
    rd(0, v); check("R7 bit14", v, 20'h0C000);
    rx2_early = 1; tick(); rx2_early = 0;
    rd(0, v); check("R7 bit11", v, 20'h08800);
    dma_mst_abort = 1; tick(); dma_mst_abort = 0;
    rd(0, v); check("R2 summary excludes bit19", v, 20'h80000);

    // R9 selective write-1 clear, then R1 read clear
    {tx_last_queued_done, tx_frame_dma_done, tx_frame_sent} = 3'b111; tick();
    {tx_last_queued_done, tx_frame_dma_done, tx_frame_sent} = 0;
    wr(0, 20'h02000);
    rd(0, v); check("R9 w1c bit13 only", v, 20'h0D000);
    rd(0, v); check("R1 second read empty", v, 20'h0);
    // R2 write to summary has no effect
    tx_frame_sent = 1; tick(); tx_frame_sent = 0;
    wr(0, 20'h08000);
    rd(0, v); check("R2 bit15 read-only", v, 20'h0C000);

    // R8 early cleared by frame done
    rx2_early = 1; tick(); rx2_early = 0;
    rx2_frame_done = 1; tick(); rx2_frame_done = 0;
    rd(0, v); check("R8 early auto clear", v, 20'h0);
    rx2_early = 1; rx2_frame_done = 1; tick(); rx2_early = 0; rx2_frame_done = 0;
    rd(0, v); check("R8 early and done together", v, 20'h0);

    // R11 set wins over clears
    tx_frame_sent = 1; rd(0, v); tx_frame_sent = 0;
    rd(0, v); check("R11 set beats read clear", v, 20'h0C000);
    tx_frame_sent = 1; wr(0, 20'h04000); tx_frame_sent = 0;
    rd(0, v); check("R11 set beats w1c", v, 20'h0C000);

    // R12 mask and irq
    tx_frame_sent = 1; tick(); tx_frame_sent = 0;
    #1 check("R12 irq masked off", {19'h0, irq}, 20'h0);
    wr(1, 20'h04000); #1 check("R12 irq bit14", {19'h0, irq}, 20'h1);
    wr(1, 20'h08000); #1 check("R12 irq via summary", {19'h0, irq}, 20'h1);
    wr(1, 20'h80000); #1 check("R12 irq other bit", {19'h0, irq}, 20'h0);
    rd(1, v); check("R12 mask readback", v, 20'h80000);
    rd(0, v); check("R12 mask read keeps status", v, 20'h0C000);
    wr(1, 20'hFFFFF);
    #1 check("R12 irq after clear", {19'h0, irq}, 20'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule